// File: doc/BRIEF.md
# Four-Slot Decode Steering with Microcode Sequencing

This block sits between an instruction queue and a bank of four decoders of unequal power. Each cycle it looks at a window of up to five pre-decoded records at the head of the queue. It places them, strictly in program order, onto the decode slots and reports how many records it used. Slot 0 is the only slot able to expand an instruction into several uops. The other slots handle single-uop instructions only. When a record needs a wide slot but is not first in the cycle, the cycle closes early, and that record becomes the first slot of the next cycle. No cycle releases more than the uop budget (four by default).

A record can ask to merge with the one after it, as a compare followed by its branch. The pair then fills a single slot and costs one uop, so five records can go out in one cycle. A record flagged as a load-op pair also costs one uop. A record whose uop count is above the budget, or which carries the microcode flag, takes over the decoders. It issues up to the budget in uops per cycle through slot 0, and the block takes no new record until the count is used up. The queue side tells the producer how many records were consumed, and the output register holds its contents while the consumer stalls.

Top module: `dec_steer`

## Requirements
- R1: Record i sits at `in_rec[i*15 +: 15]`. Bits [3:0] hold the uop count, bit 4 is the load-op flag, bit 5 is the merge-with-next flag, bit 6 is the microcode flag and bits [14:7] hold an opaque tag. With no stall, up to four slots are filled per cycle, and `out_vld` bit k marks slot k one clock after the records are taken.
- R2: Only slot 0 takes a record whose cost is 2 to 4 uops. A record of that kind met at a later slot ends the cycle and is left for the next one.
- R3: `out_uops` equals the sum of the costs of the placed records and never exceeds 4. A single-uop record that does not fit in the remaining budget ends the cycle.
- R4: A record with the merge flag is paired with the record after it, provided that record is valid in the window and costs one uop. The pair fills one slot, costs one uop, is counted as two in `in_take`, and sets the slot's `out_fused` bit. Without a valid partner, the record goes alone.
- R5: A record with the microcode flag set, or with a cost above 4, is placed only in slot 0 and ends the cycle. Slot 0 then carries min(remaining, 4) uops per cycle, with `out_mc` high and the record's tag. `in_take` stays 0 until every uop has gone out.
- R6: A record with the load-op flag costs one uop, whatever its count field says.
- R7: Records are consumed in order without gaps. `in_take` equals the number of leading valid records placed, `out_vld` is filled from slot 0 upward, and an empty window gives `in_take` 0 and an empty output.
- R8: While `out_vld` is non-zero and `out_rdy` is low, all outputs hold their values and `in_take` is 0.
- R9: While reset is asserted and until it is released, `out_vld`, `out_uops`, `out_fused` and `out_mc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | NWIN | Valid bits for the window records, filled from bit 0 upward |
| in_rec | input | NWIN*REC_W | Packed window records, record 0 oldest |
| in_take | output | TAKE_W | Number of records consumed this cycle |
| out_rdy | input | 1 | Consumer accepts the output register |
| out_vld | output | NSLOT | Per-slot valid |
| out_tag | output | NSLOT*TAG_W | Per-slot tag of the placed record |
| out_fused | output | NSLOT | Per-slot merged-pair marker |
| out_uops | output | UOPS_W | Uops released this cycle |
| out_mc | output | 1 | Output comes from a microcode record |

## Verification
The bench builds the block with its default parameters: four slots, a five-record window, a budget of four and a 4-bit uop count. With these values a single merged pair can push `in_take` to five. A count of 10 produces a three-beat microcode burst whose last beat is partial. Budget exhaustion, early cycle end on a wide record, and a merge with no valid partner can all be reached in one short window.

// File: rtl/dec_steer_pkg.sv
package dec_steer_pkg;

  // How a record is handled by the slot walker.
  typedef enum logic [1:0] {
    K_ONE   = 2'd0,   // single-uop, any slot
    K_MULTI = 2'd1,   // 2..budget uops, slot 0 only
    K_MCODE = 2'd2    // sequenced over several cycles
  } ikind_e;

endpackage

// File: rtl/dec_rst_sync.sv
module dec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dec_slot_pick.sv
module dec_slot_pick
  import dec_steer_pkg::*;
#(
  parameter int NSLOT   = 4,
  parameter int NWIN    = NSLOT + 1,
  parameter int UOP_CAP = 4,
  parameter int UCNT_W  = 4,
  parameter int TAG_W   = 8,
  localparam int REC_W  = TAG_W + UCNT_W + 3,
  localparam int TAKE_W = $clog2(NWIN + 1),
  localparam int UOPS_W = $clog2(UOP_CAP + 1)
) (
  input  logic                   en,
  input  logic [NWIN-1:0]        rec_vld,
  input  logic [NWIN*REC_W-1:0]  rec_bus,
  output logic [TAKE_W-1:0]      take,
  output logic [NSLOT-1:0]       slot_vld,
  output logic [NSLOT*TAG_W-1:0] slot_tag,
  output logic [NSLOT-1:0]       slot_fused,
  output logic [UOPS_W-1:0]      uop_sum,
  output logic                   mc_start,
  output logic [UCNT_W-1:0]      mc_count
);

  // Per-record decoded fields.
  logic [UCNT_W-1:0] r_cost  [NWIN];
  logic [TAG_W-1:0]  r_tag   [NWIN];
  ikind_e            r_kind  [NWIN];
  logic              r_pair  [NWIN];

  genvar gi;
  generate
    for (gi = 0; gi < NWIN; gi++) begin : g_rec
      logic [REC_W-1:0]  rec;
      logic [UCNT_W-1:0] cnt;
      logic              lop, mrg, mcf;

      assign rec = rec_bus[gi*REC_W +: REC_W];
      assign cnt = rec[UCNT_W-1:0];
      assign lop = rec[UCNT_W];
      assign mrg = rec[UCNT_W+1];
      assign mcf = rec[UCNT_W+2];
      assign r_tag[gi] = rec[REC_W-1 -: TAG_W];

      // Load-op records and zero counts cost one uop.
      assign r_cost[gi] = (lop || cnt == '0) ? UCNT_W'(1) : cnt;

      always_comb begin
        if (mcf || int'(r_cost[gi]) > UOP_CAP) r_kind[gi] = K_MCODE;
        else if (r_cost[gi] > UCNT_W'(1))      r_kind[gi] = K_MULTI;
        else                                   r_kind[gi] = K_ONE;
      end
    end

    // Merge partner must be present and single-uop.
    for (gi = 0; gi < NWIN - 1; gi++) begin : g_pair
      assign r_pair[gi] = rec_bus[gi*REC_W + UCNT_W + 1] && rec_vld[gi+1] &&
                          (r_kind[gi+1] == K_ONE) && (r_kind[gi] == K_ONE);
    end
    assign r_pair[NWIN-1] = 1'b0;
  endgenerate

  // In-order walk over the slots.
  always_comb begin
    int   idx;
    int   bud;
    int   tot;
    logic halt;

    idx        = 0;
    bud        = UOP_CAP;
    tot        = 0;
    halt       = !en;
    slot_vld   = '0;
    slot_tag   = '0;
    slot_fused = '0;
    mc_start   = 1'b0;
    mc_count   = '0;

    for (int s = 0; s < NSLOT; s++) begin
      if (!halt) begin
        if (idx >= NWIN) begin
          halt = 1'b1;
        end else if (!rec_vld[idx]) begin
          halt = 1'b1;
        end else begin
          case (r_kind[idx])
            K_MCODE: begin
              if (s == 0) begin
                slot_vld[s]               = 1'b1;
                slot_tag[s*TAG_W +: TAG_W] = r_tag[idx];
                mc_start                  = 1'b1;
                mc_count                  = r_cost[idx];
                tot = (int'(r_cost[idx]) > UOP_CAP) ? UOP_CAP : int'(r_cost[idx]);
                idx = idx + 1;
              end
              halt = 1'b1;
            end
            K_MULTI: begin
              if (s != 0 || int'(r_cost[idx]) > bud) begin
                halt = 1'b1;
              end else begin
                slot_vld[s]               = 1'b1;
                slot_tag[s*TAG_W +: TAG_W] = r_tag[idx];
                bud = bud - int'(r_cost[idx]);
                tot = tot + int'(r_cost[idx]);
                idx = idx + 1;
              end
            end
            default: begin
              if (bud < 1) begin
                halt = 1'b1;
              end else begin
                slot_vld[s]               = 1'b1;
                slot_tag[s*TAG_W +: TAG_W] = r_tag[idx];
                slot_fused[s]             = r_pair[idx];
                bud = bud - 1;
                tot = tot + 1;
                idx = idx + (r_pair[idx] ? 2 : 1);
              end
            end
          endcase
        end
      end
    end

    take    = TAKE_W'(idx);
    uop_sum = UOPS_W'(tot);
  end

endmodule

// File: rtl/dec_mcode_seq.sv
module dec_mcode_seq #(
  parameter int UOP_CAP = 4,
  parameter int UCNT_W  = 4,
  parameter int TAG_W   = 8,
  localparam int UOPS_W = $clog2(UOP_CAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [UCNT_W-1:0] load_cnt,
  input  logic [TAG_W-1:0]  load_tag,
  input  logic              step,
  output logic              busy,
  output logic [UOPS_W-1:0] chunk,
  output logic [TAG_W-1:0]  tag_q
);

  localparam logic [UCNT_W-1:0] CAP = UCNT_W'(UOP_CAP);

  logic [UCNT_W-1:0] rem_q, rem_d;
  logic [TAG_W-1:0]  tag_d;

  assign busy  = (rem_q != '0);
  assign chunk = (rem_q > CAP) ? UOPS_W'(UOP_CAP) : UOPS_W'(rem_q);

  always_comb begin
    rem_d = rem_q;
    tag_d = tag_q;
    if (load) begin
      rem_d = (load_cnt > CAP) ? load_cnt - CAP : '0;
      tag_d = load_tag;
    end else if (step && busy) begin
      rem_d = (rem_q > CAP) ? rem_q - CAP : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      tag_q <= '0;
    end else begin
      rem_q <= rem_d;
      tag_q <= tag_d;
    end
  end

endmodule

// File: rtl/dec_out_stage.sv
module dec_out_stage #(
  parameter int NSLOT  = 4,
  parameter int TAG_W  = 8,
  parameter int UOPS_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [NSLOT-1:0]       d_vld,
  input  logic [NSLOT*TAG_W-1:0] d_tag,
  input  logic [NSLOT-1:0]       d_fused,
  input  logic [UOPS_W-1:0]      d_uops,
  input  logic                   d_mc,
  output logic [NSLOT-1:0]       q_vld,
  output logic [NSLOT*TAG_W-1:0] q_tag,
  output logic [NSLOT-1:0]       q_fused,
  output logic [UOPS_W-1:0]      q_uops,
  output logic                   q_mc
);

  logic [NSLOT-1:0]       n_vld;
  logic [NSLOT*TAG_W-1:0] n_tag;
  logic [NSLOT-1:0]       n_fused;
  logic [UOPS_W-1:0]      n_uops;
  logic                   n_mc;

  always_comb begin
    n_vld   = q_vld;
    n_tag   = q_tag;
    n_fused = q_fused;
    n_uops  = q_uops;
    n_mc    = q_mc;
    if (load) begin
      n_vld   = d_vld;
      n_tag   = d_tag;
      n_fused = d_fused;
      n_uops  = d_uops;
      n_mc    = d_mc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld   <= '0;
      q_tag   <= '0;
      q_fused <= '0;
      q_uops  <= '0;
      q_mc    <= 1'b0;
    end else begin
      q_vld   <= n_vld;
      q_tag   <= n_tag;
      q_fused <= n_fused;
      q_uops  <= n_uops;
      q_mc    <= n_mc;
    end
  end

endmodule

// File: rtl/dec_steer.sv
module dec_steer #(
  parameter int NSLOT   = 4,
  parameter int NWIN    = NSLOT + 1,
  parameter int UOP_CAP = 4,
  parameter int UCNT_W  = 4,
  parameter int TAG_W   = 8,
  localparam int REC_W  = TAG_W + UCNT_W + 3,
  localparam int TAKE_W = $clog2(NWIN + 1),
  localparam int UOPS_W = $clog2(UOP_CAP + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NWIN-1:0]        in_vld,
  input  logic [NWIN*REC_W-1:0]  in_rec,
  output logic [TAKE_W-1:0]      in_take,
  input  logic                   out_rdy,
  output logic [NSLOT-1:0]       out_vld,
  output logic [NSLOT*TAG_W-1:0] out_tag,
  output logic [NSLOT-1:0]       out_fused,
  output logic [UOPS_W-1:0]      out_uops,
  output logic                   out_mc
);

  logic                   srst_n;
  logic                   out_adv;
  logic                   pick_en;
  logic                   mc_busy;
  logic [UOPS_W-1:0]      mc_chunk;
  logic [TAG_W-1:0]       mc_tag;

  logic [TAKE_W-1:0]      p_take;
  logic [NSLOT-1:0]       p_vld;
  logic [NSLOT*TAG_W-1:0] p_tag;
  logic [NSLOT-1:0]       p_fused;
  logic [UOPS_W-1:0]      p_uops;
  logic                   p_mc_start;
  logic [UCNT_W-1:0]      p_mc_cnt;

  logic [NSLOT-1:0]       d_vld;
  logic [NSLOT*TAG_W-1:0] d_tag;
  logic [NSLOT-1:0]       d_fused;
  logic [UOPS_W-1:0]      d_uops;
  logic                   d_mc;

  dec_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (srst_n)
  );

  // Output register may advance when empty or drained this cycle.
  assign out_adv = (out_vld == '0) || out_rdy;
  assign pick_en = out_adv && !mc_busy;

  dec_slot_pick #(
    .NSLOT(NSLOT), .NWIN(NWIN), .UOP_CAP(UOP_CAP), .UCNT_W(UCNT_W), .TAG_W(TAG_W)
  ) u_pick (
    .en         (pick_en),
    .rec_vld    (in_vld),
    .rec_bus    (in_rec),
    .take       (p_take),
    .slot_vld   (p_vld),
    .slot_tag   (p_tag),
    .slot_fused (p_fused),
    .uop_sum    (p_uops),
    .mc_start   (p_mc_start),
    .mc_count   (p_mc_cnt)
  );

  dec_mcode_seq #(
    .UOP_CAP(UOP_CAP), .UCNT_W(UCNT_W), .TAG_W(TAG_W)
  ) u_mc (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (p_mc_start),
    .load_cnt (p_mc_cnt),
    .load_tag (p_tag[TAG_W-1:0]),
    .step     (out_adv),
    .busy     (mc_busy),
    .chunk    (mc_chunk),
    .tag_q    (mc_tag)
  );

  assign in_take = p_take;

  always_comb begin
    if (mc_busy) begin
      d_vld            = '0;
      d_vld[0]         = 1'b1;
      d_tag            = '0;
      d_tag[TAG_W-1:0] = mc_tag;
      d_fused          = '0;
      d_uops           = mc_chunk;
      d_mc             = 1'b1;
    end else begin
      d_vld   = p_vld;
      d_tag   = p_tag;
      d_fused = p_fused;
      d_uops  = p_uops;
      d_mc    = p_mc_start;
    end
  end

  dec_out_stage #(
    .NSLOT(NSLOT), .TAG_W(TAG_W), .UOPS_W(UOPS_W)
  ) u_out (
    .clk     (clk),
    .rst_n   (srst_n),
    .load    (out_adv),
    .d_vld   (d_vld),
    .d_tag   (d_tag),
    .d_fused (d_fused),
    .d_uops  (d_uops),
    .d_mc    (d_mc),
    .q_vld   (out_vld),
    .q_tag   (out_tag),
    .q_fused (out_fused),
    .q_uops  (out_uops),
    .q_mc    (out_mc)
  );

endmodule

// File: rtl/dec_steer_chk.sv
module dec_steer_chk #(
  parameter int NSLOT   = 4,
  parameter int NWIN    = 5,
  parameter int UOP_CAP = 4,
  parameter int TAG_W   = 8,
  parameter int TAKE_W  = 3,
  parameter int UOPS_W  = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NWIN-1:0]        in_vld,
  input logic [TAKE_W-1:0]      in_take,
  input logic                   out_rdy,
  input logic [NSLOT-1:0]       out_vld,
  input logic [NSLOT*TAG_W-1:0] out_tag,
  input logic [UOPS_W-1:0]      out_uops,
  input logic                   out_mc,
  input logic                   mc_busy
);

  // R3
  uop_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(out_uops) <= UOP_CAP);

  // R7
  slot_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_vld + 1'b1) & out_vld) == '0);

  // R7
  take_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(in_take) <= $countones(in_vld));

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld != '0 && !out_rdy) |=> ($stable(out_vld) && $stable(out_uops) && $stable(out_tag)));

  // R8
  stall_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld != '0 && !out_rdy) |-> in_take == '0);

  // R5
  mc_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mc_busy |-> in_take == '0);

  // R5
  mc_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_mc |-> out_vld[NSLOT-1:1] == '0);

endmodule

bind dec_steer dec_steer_chk #(
  .NSLOT(NSLOT), .NWIN(NWIN), .UOP_CAP(UOP_CAP), .TAG_W(TAG_W),
  .TAKE_W(TAKE_W), .UOPS_W(UOPS_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_vld   (in_vld),
  .in_take  (in_take),
  .out_rdy  (out_rdy),
  .out_vld  (out_vld),
  .out_tag  (out_tag),
  .out_uops (out_uops),
  .out_mc   (out_mc),
  .mc_busy  (mc_busy)
);

// File: tb/test_dec_steer.sv
module test_dec_steer;

  localparam int NSLOT  = 4;
  localparam int NWIN   = 5;
  localparam int UCNT_W = 4;
  localparam int TAG_W  = 8;
  localparam int REC_W  = TAG_W + UCNT_W + 3;

  // Record low bits {mcode, merge, load-op, count[3:0]}
  localparam logic [6:0] X   = 7'h00;
  localparam logic [6:0] S   = 7'h01;
  localparam logic [6:0] C2  = 7'h02;
  localparam logic [6:0] C3  = 7'h03;
  localparam logic [6:0] C4  = 7'h04;
  localparam logic [6:0] F   = 7'h21;
  localparam logic [6:0] U3  = 7'h13;
  localparam logic [6:0] M10 = 7'h0A;
  localparam logic [6:0] MF3 = 7'h43;

  // {in_vld, r0..r4, exp_take, exp_vld, exp_uops}
  localparam int NVEC = 13;
  localparam logic [49:0] VEC [NVEC] = '{
    {5'b11111, S,  S,  S,  S,  S, 3'd4, 4'b1111, 3'd4},  // R1 four simple
    {5'b01111, C3, S,  S,  S,  X, 3'd2, 4'b0011, 3'd4},  // R3 budget
    {5'b00111, S,  C2, S,  X,  X, 3'd1, 4'b0001, 3'd1},  // R2 wide waits
    {5'b11111, F,  S,  S,  S,  S, 3'd5, 4'b1111, 3'd4},  // R4 five taken
    {5'b01111, U3, S,  S,  S,  X, 3'd4, 4'b1111, 3'd4},  // R6 load-op
    {5'b00011, C4, S,  X,  X,  X, 3'd1, 4'b0001, 3'd4},  // R3 full
    {5'b00011, S,  S,  X,  X,  X, 3'd2, 4'b0011, 3'd2},  // R7 short
    {5'b00000, X,  X,  X,  X,  X, 3'd0, 4'b0000, 3'd0},  // R7 empty
    {5'b00001, F,  X,  X,  X,  X, 3'd1, 4'b0001, 3'd1},  // R4 no partner
    {5'b01111, S,  S,  S,  C2, X, 3'd3, 4'b0111, 3'd3},  // R2 late wide
    {5'b00011, C2, C2, X,  X,  X, 3'd1, 4'b0001, 3'd2},  // R2 two wide
    {5'b11111, S,  S,  F,  S,  S, 3'd5, 4'b1111, 3'd4},  // R4 mid pair
    {5'b01111, C2, S,  S,  S,  X, 3'd3, 4'b0111, 3'd4}   // R3 cut
  };

  logic                   clk;
  logic                   rst_n;
  logic [NWIN-1:0]        in_vld;
  logic [NWIN*REC_W-1:0]  in_rec;
  logic [2:0]             in_take;
  logic                   out_rdy;
  logic [NSLOT-1:0]       out_vld;
  logic [NSLOT*TAG_W-1:0] out_tag;
  logic [NSLOT-1:0]       out_fused;
  logic [2:0]             out_uops;
  logic                   out_mc;

  int n_chk;
  int n_fail;

  dec_steer i_dec_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .in_rec    (in_rec),
    .in_take   (in_take),
    .out_rdy   (out_rdy),
    .out_vld   (out_vld),
    .out_tag   (out_tag),
    .out_fused (out_fused),
    .out_uops  (out_uops),
    .out_mc    (out_mc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic set_win(input logic [4:0] v, input logic [34:0] rs, input int base);
    in_vld = v;
    for (int i = 0; i < NWIN; i++)
      in_rec[i*REC_W +: REC_W] = {8'(base + i), rs[34-7*i -: 7]};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: got %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    n_chk   = 0;
    n_fail  = 0;
    rst_n   = 1'b0;
    out_rdy = 1'b1;
    in_vld  = '0;
    in_rec  = '0;

    // R9 reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "out_vld", int'(out_vld), 0);
    chk("R9", "out_uops", int'(out_uops), 0);
    chk("R9", "out_mc", int'(out_mc), 0);
    chk("R9", "out_fused", int'(out_fused), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      set_win(VEC[v][49:45], VEC[v][44:10], v * 8);
      #1;
      chk("R7", $sformatf("take vec %0d", v), int'(in_take), int'(VEC[v][9:7]));
      @(posedge clk);
      #1;
      chk("R1", $sformatf("slots vec %0d", v), int'(out_vld), int'(VEC[v][6:3]));
      chk("R3", $sformatf("uops vec %0d", v), int'(out_uops), int'(VEC[v][2:0]));
    end

    // R4 pair tags and marker
    @(negedge clk);
    set_win(5'b11111, {F, S, S, S, S}, 8'h40);
    @(posedge clk);
    #1;
    chk("R4", "fused mask", int'(out_fused), 1);
    chk("R4", "slot0 tag", int'(out_tag[7:0]), 8'h40);
    chk("R4", "slot1 tag", int'(out_tag[15:8]), 8'h42);
    chk("R4", "slot3 tag", int'(out_tag[31:24]), 8'h44);

    // R5 microcode burst of 10 uops
    @(negedge clk);
    set_win(5'b00011, {M10, S, X, X, X}, 8'h80);
    #1;
    chk("R5", "mc take", int'(in_take), 1);
    @(posedge clk);
    #1;
    chk("R5", "mc beat1 uops", int'(out_uops), 4);
    chk("R5", "mc beat1 flag", int'(out_mc), 1);
    @(negedge clk);
    set_win(5'b00001, {S, X, X, X, X}, 8'h90);
    #1;
    chk("R5", "mc busy take", int'(in_take), 0);
    @(posedge clk);
    #1;
    chk("R5", "mc beat2 uops", int'(out_uops), 4);
    chk("R5", "mc beat2 tag", int'(out_tag[7:0]), 8'h80);
    #4;
    chk("R5", "mc busy take2", int'(in_take), 0);
    @(posedge clk);
    #1;
    chk("R5", "mc beat3 uops", int'(out_uops), 2);
    chk("R5", "mc beat3 slots", int'(out_vld), 1);
    #4;
    chk("R5", "resume take", int'(in_take), 1);
    @(posedge clk);
    #1;
    chk("R5", "resume flag", int'(out_mc), 0);
    chk("R5", "resume tag", int'(out_tag[7:0]), 8'h90);

    // R5 microcode flag on a small record
    @(negedge clk);
    set_win(5'b00011, {MF3, S, X, X, X}, 8'hA0);
    #1;
    chk("R5", "flag take", int'(in_take), 1);
    @(posedge clk);
    #1;
    chk("R5", "flag uops", int'(out_uops), 3);
    chk("R5", "flag mc", int'(out_mc), 1);

    // R8 backpressure
    @(negedge clk);
    set_win(5'b00011, {S, S, X, X, X}, 8'hB0);
    @(posedge clk);
    @(negedge clk);
    out_rdy = 1'b0;
    set_win(5'b01111, {S, S, S, S, X}, 8'hC0);
    #1;
    chk("R8", "stall take", int'(in_take), 0);
    @(posedge clk);
    #1;
    chk("R8", "held slots", int'(out_vld), 3);
    chk("R8", "held uops", int'(out_uops), 2);
    chk("R8", "held tag", int'(out_tag[7:0]), 8'hB0);
    @(negedge clk);
    out_rdy = 1'b1;
    #1;
    chk("R8", "release take", int'(in_take), 4);
    @(posedge clk);
    #1;
    chk("R8", "release slots", int'(out_vld), 15);

    summary();
    $finish;
  end

endmodule